// File: doc/BRIEF.md
# Ones' Complement Adder/Subtractor

A purely combinational adder/subtractor for ones' complement integers of a parameterised width (four bits by default). Two operands and an add/subtract select come in; the result and an overflow flag go out in the same cycle. Negation in this number system is the bitwise complement, so subtraction feeds the inverted second operand into the same adder.

When the binary sum of the two effective addends carries out of the sign position, that carry is added back at the least significant position. This is the end-around carry. The block does it with a second carry-propagate pass rather than a combinational feedback path. Both encodings of zero, all zeros and all ones, are legal on the inputs. The main adder can be built as a ripple chain or as a full carry-lookahead network, chosen by a parameter.

Top module: `ones_comp_addsub`

## Requirements
- R1: With sub_i = 0 and no overflow, the value of sum_o is the value of a_i plus the value of b_i. A word with MSB 1 has value minus the bitwise complement of its bits. A word with MSB 0 has its plain binary value.
- R2: With sub_i = 1 and no overflow, the value of sum_o is the value of a_i minus the value of b_i. This is formed as a_i plus the bitwise complement of b_i.
- R3: ovf_o is 1 exactly when the true sum or difference lies outside the range -(2^(W-1)-1) to +(2^(W-1)-1), which is -7 to +7 for W = 4. Equivalently, the two effective addends share an MSB and the result MSB differs from it, as in 0101+0011 giving 1000.
- R4: Let R be the (W+1)-bit binary sum of a_i and the effective second operand. When bit W of R is set, sum_o equals the low W bits of R plus one. Otherwise sum_o equals R. For example, 0100+0011 gives 0111, and 1011+1100 gives 1000. This also holds when ovf_o is 1.
- R5: A zero result is encoded as all zeros only when both effective addends are all zeros. Every other zero result is all ones.
- R6: Both all-zeros and all-ones inputs act as zero. For example, 0101+1111 gives 0101, and 0101-1111 gives 0101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand, ones' complement |
| b_i | input | W | Second operand, ones' complement |
| sub_i | input | 1 | 0: add, 1: subtract b_i from a_i |
| sum_o | output | W | Result, ones' complement |
| ovf_o | output | 1 | Result out of representable range |

## Verification
The block holds no state, so any internal fault shows at sum_o or ovf_o for the very input pair that exercises it, with no delay. If the end-around carry is lost, every pair whose raw sum carries out is off by one, as in -4 + -3. If the carry is applied twice or unconditionally, results between non-negative operands shift. A wrong operand select or overflow term separates the subtract half or the sign-boundary pairs from the reference. Sweeping every operand pair in both modes therefore exposes each such fault at the first affected vector.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int unsigned DefWidth = 4;

  function automatic logic is_neg(input logic msb);
    return msb;
  endfunction
endpackage

// File: rtl/oc_operand_sel.sv
module oc_operand_sel #(
  parameter int unsigned W = oc_pkg::DefWidth
) (
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] b_eff_o
);
  for (genvar i = 0; i < W; i++) begin : g_inv
    assign b_eff_o[i] = b_i[i] ^ sub_i;
  end
endmodule

// File: rtl/oc_cpa.sv
module oc_cpa #(
  parameter int unsigned W         = oc_pkg::DefWidth,
  parameter bit          LOOKAHEAD = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] gen, prop;
  logic [W:0]   carry;

  assign gen  = a_i & b_i;
  assign prop = a_i ^ b_i;
  assign carry[0] = cin_i;

  if (LOOKAHEAD) begin : g_cla
    // each carry as a flat sum of generate/propagate products
    always_comb begin
      logic acc;
      logic term;
      for (int i = 0; i < W; i++) begin
        acc = cin_i;
        for (int k = 0; k <= i; k++) acc = acc & prop[k];
        for (int j = 0; j <= i; j++) begin
          term = gen[j];
          for (int k = j + 1; k <= i; k++) term = term & prop[k];
          acc = acc | term;
        end
        carry[i+1] = acc;
      end
    end
  end else begin : g_ripple
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
    end
  end

  assign sum_o  = prop ^ carry[W-1:0];
  assign cout_o = carry[W];

  always_comb begin
    p_cpa_sum_r4: assert ({cout_o, sum_o} ==
      ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("cpa sum mismatch");
  end
endmodule

// File: rtl/oc_ovf_detect.sv
module oc_ovf_detect (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic s_msb_i,
  output logic ovf_o
);
  assign ovf_o = (oc_pkg::is_neg(a_msb_i) == oc_pkg::is_neg(b_msb_i)) &&
                 (s_msb_i != a_msb_i);
endmodule

// File: rtl/ones_comp_addsub.sv
module ones_comp_addsub #(
  parameter int unsigned W         = oc_pkg::DefWidth,
  parameter bit          LOOKAHEAD = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff, raw_sum, fin_sum;
  logic         raw_cout, fin_cout;

  oc_operand_sel #(.W(W)) u_sel (
    .b_i    (b_i),
    .sub_i  (sub_i),
    .b_eff_o(b_eff)
  );

  oc_cpa #(.W(W), .LOOKAHEAD(LOOKAHEAD)) u_main (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (1'b0),
    .sum_o (raw_sum),
    .cout_o(raw_cout)
  );

  // end-around carry as a second pass: no combinational loop
  oc_cpa #(.W(W), .LOOKAHEAD(1'b0)) u_wrap (
    .a_i   (raw_sum),
    .b_i   ({W{1'b0}}),
    .cin_i (raw_cout),
    .sum_o (fin_sum),
    .cout_o(fin_cout)
  );

  oc_ovf_detect u_ovf (
    .a_msb_i(a_i[W-1]),
    .b_msb_i(b_eff[W-1]),
    .s_msb_i(fin_sum[W-1]),
    .ovf_o  (ovf_o)
  );

  assign sum_o = fin_sum;

  always_comb begin
    p_no_second_carry_r4: assert (!fin_cout)
      else $error("end-around pass carried out");
    p_ovf_same_sign_r3: assert (!ovf_o || (a_i[W-1] == b_eff[W-1]))
      else $error("overflow with mixed signs");
    p_plus_zero_r5: assert ((fin_sum != '0) || ((a_i == '0) && (b_eff == '0)))
      else $error("all-zero result from nonzero addends");
  end
endmodule

// File: tb/tb_ones_comp_addsub.sv
`timescale 1ns/1ps
module tb_ones_comp_addsub;
  localparam int N = 4;
  localparam int MAXV = (1 << (N - 1)) - 1;
  localparam int MASK = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] a, b, sum;
  logic sub, ovf;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ones_comp_addsub #(.W(N)) dut (
    .a_i(a), .b_i(b), .sub_i(sub), .sum_o(sum), .ovf_o(ovf)
  );

  function automatic int val(input logic [N-1:0] x);
    return x[N-1] ? -int'((~x) & MASK) : int'(x);
  endfunction

  function automatic logic [N-1:0] wrap_sum(input logic [N-1:0] x, input logic [N-1:0] y);
    int r;
    r = int'(x) + int'(y);
    if (r > MASK) r = r - MASK;
    return r[N-1:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%b b=%b sub=%0b: actual %0d expected %0d", req, a, b, sub, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] av, input logic [N-1:0] bv, input logic sv);
    @(negedge clk);
    a = av; b = bv; sub = sv;
    #1;
  endtask

  task automatic t_idle_state;
    apply('0, '0, 1'b0);
    chk("R5 idle sum", int'(sum), 0);
    chk("R3 idle ovf", int'(ovf), 0);
  endtask

  task automatic t_examples;
    apply(4'b0100, 4'b0011, 1'b0);
    chk("R4 4+3", int'(sum), 4'b0111);
    apply(4'b1011, 4'b1100, 1'b0);
    chk("R4 -4+-3", int'(sum), 4'b1000);
    chk("R3 -4+-3 ovf", int'(ovf), 0);
    apply(4'b0100, 4'b0011, 1'b1);
    chk("R2 4-3", int'(sum), 4'b0001);
  endtask

  task automatic t_zero_forms;
    apply(4'b0101, 4'b1111, 1'b0);
    chk("R6 5+-0", int'(sum), 4'b0101);
    apply(4'b0101, 4'b1111, 1'b1);
    chk("R6 5--0", int'(sum), 4'b0101);
    apply(4'b0000, 4'b1111, 1'b0);
    chk("R5 +0+-0", int'(sum), 4'b1111);
    apply(4'b1111, 4'b1111, 1'b0);
    chk("R5 -0+-0", int'(sum), 4'b1111);
    apply(4'b0011, 4'b0011, 1'b1);
    chk("R5 3-3", int'(sum), 4'b1111);
    apply(4'b0000, 4'b1111, 1'b1);
    chk("R5 +0 minus -0", int'(sum), 4'b0000);
  endtask

  task automatic t_overflow_edges;
    apply(4'b0101, 4'b0011, 1'b0);
    chk("R3 5+3 ovf", int'(ovf), 1);
    chk("R4 5+3 bits", int'(sum), 4'b1000);
    apply(4'b1000, 4'b0010, 1'b1);
    chk("R3 -7-2 ovf", int'(ovf), 1);
    apply(4'b0111, 4'b0000, 1'b0);
    chk("R3 7+0 no ovf", int'(ovf), 0);
    apply(4'b1000, 4'b1111, 1'b0);
    chk("R3 -7+-0 no ovf", int'(ovf), 0);
  endtask

  task automatic t_sweep(input logic sv);
    for (int i = 0; i <= MASK; i++) begin
      for (int j = 0; j <= MASK; j++) begin
        logic [N-1:0] beff;
        int exact, expv;
        bit exp_ovf;
        apply(i[N-1:0], j[N-1:0], sv);
        beff = sv ? ~j[N-1:0] : j[N-1:0];
        exact = sv ? val(a) - val(b) : val(a) + val(b);
        exp_ovf = (exact > MAXV) || (exact < -MAXV);
        chk("R3 sweep ovf", int'(ovf), int'(exp_ovf));
        chk("R4 sweep bits", int'(sum), int'(wrap_sum(a, beff)));
        if (!exp_ovf) begin
          expv = exact;
          if (sv) chk("R2 sweep value", val(sum), expv);
          else    chk("R1 sweep value", val(sum), expv);
        end
      end
    end
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_idle_state();
        t_examples();
        t_zero_forms();
        t_overflow_edges();
        t_sweep(1'b0);
        t_sweep(1'b1);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule